// File: doc/BRIEF.md
# Buffered Resolution-Selectable PWM Channel

This block produces one pulse-width-modulated output from a free-running counter that lives outside it. A three-bit resolution code picks how many low counter bits form one period (16, 15, 14, 13, 12, 11, 9 or 7), so the output frequency is the counter rate divided by two to that power. Software writes a pulse-width value into a holding register. The block copies that value into the working compare register only when the selected counter bits roll over to zero. As a result a period never mixes an old width with a new one.

When fewer than 16 bits are in use, the top bit of the compare value is spare and holds the output high for the whole period. At full resolution that bit is an ordinary compare bit, so the output always has at least one low count per period. The block also has a push-pull or open-drain drive choice, a rollover flag with a leveled interrupt request, and a freeze input that pauses the channel without losing its state. The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level that is sampled or driven on each clock.

Top module: `pwm_channel`

## Requirements
- R1: While `rst_n` is low, `pwm_o`, `flag_o`, `irq_req_o` and `irq_lvl_o` are all 0, and the holding and working compare registers clear to 0.
- R2: `mode_i` selects the period width N: 000=16, 001=15, 010=14, 011=13, 100=12, 101=11, 110=9, 111=7. Only the low N bits of `cnt_i` and of the compare value are used. A period lasts 2^N counter values, and bits above N have no effect on the waveform.
- R3: The output is registered. On the clock that samples the low N counter bits equal to zero, `pwm_o` becomes 1 from the next cycle, unless the newly loaded low N compare bits are zero. On the clock that samples those counter bits equal to the working compare bits, `pwm_o` becomes 0. Over one period, `pwm_o` is high for exactly C counter values, where C is the low N compare bits.
- R4: A write (`cmp_wr_i` high, data on `cmp_wdata_i`) changes only the holding register. The working compare value takes the holding value at the next rollover. A write in the middle of a period leaves that period's width unchanged. A write on the rollover clock itself takes effect one period later.
- R5: In modes other than 000, a compare value with bit 15 set keeps `pwm_o` high for all 2^N values of the period. Entering and leaving this forced-high state happens only at a rollover.
- R6: In mode 000, bit 15 is a normal compare bit, no forced-high state exists, and the largest value 0xFFFF still gives one low count per 65536.
- R7: `flag_o` sets on every sampled rollover and clears on the clock after `flag_clr_i` is high. When a rollover and a clear strobe fall on the same clock, the flag stays set.
- R8: `irq_req_o` is 1 exactly when `flag_o` is 1 and `irq_lvl_cfg_i` is non-zero. `irq_lvl_o` shows `irq_lvl_cfg_i` while a request is raised and is 0 otherwise.
- R9: With `od_sel_i` low, `pwm_oe_o` is always 1 (push-pull). With `od_sel_i` high, `pwm_oe_o` is 0 whenever `pwm_o` is 1, and 1 whenever `pwm_o` is 0 (open-drain).
- R10: While `freeze_i` is high, `pwm_o`, the working compare value and the flag's set path hold, whatever `cnt_i` shows. A clear strobe and holding-register writes still act. After release, the period continues from where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Free-running counter value |
| freeze_i | input | 1 | Pause request; holds all channel activity |
| mode_i | input | 3 | Resolution code |
| cmp_wr_i | input | 1 | Holding-register write strobe |
| cmp_wdata_i | input | CNT_W | Pulse-width value to write |
| od_sel_i | input | 1 | 1 = open-drain drive, 0 = push-pull |
| irq_lvl_cfg_i | input | LVL_W | Interrupt level; 0 disables the request |
| flag_clr_i | input | 1 | Flag clear strobe |
| pwm_o | output | 1 | Logical PWM output |
| pwm_oe_o | output | 1 | Output driver enable |
| flag_o | output | 1 | Rollover flag |
| irq_req_o | output | 1 | Interrupt request |
| irq_lvl_o | output | LVL_W | Level of the active request |

## Verification
Two pairs of events can meet on one clock. The first is a rollover and a flag clear strobe. The bench presents counter value zero and the clear strobe on the same edge, and expects the flag to remain set. The second is a rollover and a holding-register write. The bench writes a new width on the very clock that presents the zero count, and expects the period that follows to keep the previous width, with the new width showing only one period later. In both cases the bench counts high cycles over whole periods and compares them with the widths the requirements predict.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int DEF_CNT_W = 16;
  localparam int DEF_LVL_W = 3;
  localparam int MODE_W    = 3;

  // Period width in bits for a resolution code, relative to the full counter.
  function automatic int res_bits(input logic [MODE_W-1:0] code, input int full_w);
    case (code)
      3'd0:    return full_w;
      3'd1:    return full_w - 1;
      3'd2:    return full_w - 2;
      3'd3:    return full_w - 3;
      3'd4:    return full_w - 4;
      3'd5:    return full_w - 5;
      3'd6:    return full_w - 7;
      default: return full_w - 9;
    endcase
  endfunction

endpackage

// File: rtl/pwm_res_decode.sv
module pwm_res_decode #(
  parameter int CNT_W = pwm_chan_pkg::DEF_CNT_W
) (
  input  logic [pwm_chan_pkg::MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]                mask_o,
  output logic                            force_ok_o
);

  int nbits;

  always_comb nbits = pwm_chan_pkg::res_bits(mode_i, CNT_W);

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (i < nbits);
  end

  // The spare top bit acts as a force only below full resolution.
  assign force_ok_o = (mode_i != '0);

endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
  parameter int CNT_W = pwm_chan_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic [CNT_W-1:0] active_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_o <= '0;
    end else if (wr_i) begin
      shadow_o <= wdata_i;
    end
  end

  // The working copy takes the holding value only at a period boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= '0;
    end else if (load_i) begin
      active_o <= shadow_o;
    end
  end

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic wrap_i,
  input  logic match_i,
  input  logic start_high_i,
  input  logic hold_high_i,
  output logic out_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_o <= 1'b0;
    end else if (run_i) begin
      if (wrap_i) begin
        out_o <= start_high_i;
      end else if (match_i && !hold_high_i) begin
        out_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_flag_irq.sv
module pwm_flag_irq #(
  parameter int LVL_W = pwm_chan_pkg::DEF_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             flag_o,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o
);

  // Setting outranks clearing so that no rollover is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

  assign req_o = flag_o && (lvl_i != '0);
  assign lvl_o = req_o ? lvl_i : '0;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = pwm_chan_pkg::DEF_CNT_W,
  parameter int LVL_W = pwm_chan_pkg::DEF_LVL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic                            freeze_i,
  input  logic [pwm_chan_pkg::MODE_W-1:0] mode_i,
  input  logic                            cmp_wr_i,
  input  logic [CNT_W-1:0]                cmp_wdata_i,
  input  logic                            od_sel_i,
  input  logic [LVL_W-1:0]                irq_lvl_cfg_i,
  input  logic                            flag_clr_i,
  output logic                            pwm_o,
  output logic                            pwm_oe_o,
  output logic                            flag_o,
  output logic                            irq_req_o,
  output logic [LVL_W-1:0]                irq_lvl_o
);

  localparam int TOP_BIT = CNT_W - 1;

  logic [CNT_W-1:0] mask;
  logic             force_ok;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;
  logic             run;
  logic             wrap;
  logic             match;
  logic             load;
  logic             start_high;
  logic             hold_high;
  logic             out_q;

  pwm_res_decode #(.CNT_W(CNT_W)) u_dec (
    .mode_i     (mode_i),
    .mask_o     (mask),
    .force_ok_o (force_ok)
  );

  assign run   = !freeze_i;
  assign wrap  = ((cnt_i & mask) == '0);
  assign match = (((cnt_i ^ active_q) & mask) == '0);
  assign load  = run && wrap;

  pwm_cmp_buf #(.CNT_W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cmp_wr_i),
    .wdata_i  (cmp_wdata_i),
    .load_i   (load),
    .shadow_o (shadow_q),
    .active_o (active_q)
  );

  // Level for the new period comes from the value being loaded.
  assign start_high = (force_ok && shadow_q[TOP_BIT]) || ((shadow_q & mask) != '0);
  assign hold_high  = force_ok && active_q[TOP_BIT];

  pwm_wave_gen u_wave (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .wrap_i       (wrap),
    .match_i      (match),
    .start_high_i (start_high),
    .hold_high_i  (hold_high),
    .out_o        (out_q)
  );

  pwm_flag_irq #(.LVL_W(LVL_W)) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (load),
    .clr_i  (flag_clr_i),
    .lvl_i  (irq_lvl_cfg_i),
    .flag_o (flag_o),
    .req_o  (irq_req_o),
    .lvl_o  (irq_lvl_o)
  );

  assign pwm_o    = out_q;
  assign pwm_oe_o = od_sel_i ? !out_q : 1'b1;

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int CNT_W = pwm_chan_pkg::DEF_CNT_W,
  parameter int LVL_W = pwm_chan_pkg::DEF_LVL_W
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [CNT_W-1:0]                cnt_i,
  input logic                            freeze_i,
  input logic [pwm_chan_pkg::MODE_W-1:0] mode_i,
  input logic                            od_sel_i,
  input logic [LVL_W-1:0]                irq_lvl_cfg_i,
  input logic                            flag_clr_i,
  input logic                            pwm_o,
  input logic                            pwm_oe_o,
  input logic                            flag_o,
  input logic                            irq_req_o,
  input logic [LVL_W-1:0]                irq_lvl_o
);

  int               ck_bits;
  logic [CNT_W-1:0] ck_mask;
  logic             ck_roll;

  always_comb begin
    ck_bits = pwm_chan_pkg::res_bits(mode_i, CNT_W);
    for (int i = 0; i < CNT_W; i++) ck_mask[i] = (i < ck_bits);
    ck_roll = ((cnt_i & ck_mask) == '0);
  end

  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(pwm_o));

  assert_no_set_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !flag_o) |=> !flag_o);

  assert_flag_on_roll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && ck_roll) |=> flag_o);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !(ck_roll && !freeze_i)) |=> !flag_o);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (flag_o && irq_lvl_cfg_i != '0 && irq_lvl_o == irq_lvl_cfg_i));

  assert_od_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (od_sel_i && pwm_o) |-> !pwm_oe_o);

  assert_pp_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !od_sel_i |-> pwm_oe_o);

endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_i         (cnt_i),
  .freeze_i      (freeze_i),
  .mode_i        (mode_i),
  .od_sel_i      (od_sel_i),
  .irq_lvl_cfg_i (irq_lvl_cfg_i),
  .flag_clr_i    (flag_clr_i),
  .pwm_o         (pwm_o),
  .pwm_oe_o      (pwm_oe_o),
  .flag_o        (flag_o),
  .irq_req_o     (irq_req_o),
  .irq_lvl_o     (irq_lvl_o)
);

// File: tb/pwm_channel_tb_top.sv
`timescale 1ns/1ps
module pwm_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0001;
  logic        freeze = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic        wr = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic        od = 1'b0;
  logic [2:0]  lvl = 3'd0;
  logic        fclr = 1'b0;
  logic        pwm;
  logic        oe;
  logic        flag;
  logic        irq;
  logic [2:0]  irq_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_channel dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_i         (cnt),
    .freeze_i      (freeze),
    .mode_i        (mode),
    .cmp_wr_i      (wr),
    .cmp_wdata_i   (wdata),
    .od_sel_i      (od),
    .irq_lvl_cfg_i (lvl),
    .flag_clr_i    (fclr),
    .pwm_o         (pwm),
    .pwm_oe_o      (oe),
    .flag_o        (flag),
    .irq_req_o     (irq),
    .irq_lvl_o     (irq_lvl)
  );

  localparam int NV = 11;
  localparam logic [2:0]  V_MODE [NV] = '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7,
                                          3'd6, 3'd6, 3'd6, 3'd5, 3'd4, 3'd7};
  localparam logic [15:0] V_VAL  [NV] = '{16'h0040, 16'h0000, 16'h8000, 16'h007F, 16'h0F85,
                                          16'h0100, 16'h8003, 16'h7E01, 16'h0400, 16'h0800,
                                          16'hFF80};
  localparam int          V_EXP  [NV] = '{64, 0, 128, 127, 5,
                                          256, 512, 1, 1024, 2048, 128};

  function automatic int period_of(input logic [2:0] m);
    case (m)
      3'd0: return 65536;
      3'd1: return 32768;
      3'd2: return 16384;
      3'd3: return 8192;
      3'd4: return 4096;
      3'd5: return 2048;
      3'd6: return 512;
      default: return 128;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Count high samples over p counter values; optional write at step 'at'.
  task automatic measure(input int p, input int at, input logic [15:0] val, output int highs);
    highs = 0;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      if (pwm) highs++;
      wr = (k == at);
      if (k == at) wdata = val;
      cnt = cnt + 16'd1;
    end
    wr = 1'b0;
  endtask

  task automatic load_and_measure(input logic [2:0] m, input logic [15:0] val, output int highs);
    @(negedge clk);
    mode = m; wr = 1'b1; wdata = val; cnt = 16'h0001;
    @(negedge clk);
    wr = 1'b0; cnt = 16'h0000;
    measure(period_of(m), -1, 16'h0000, highs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int h;
    int bad;
    logic held;
    logic [15:0] saved;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwm == 1'b0 && flag == 1'b0 && irq == 1'b0 && irq_lvl == 3'd0 && oe == 1'b1,
          "R1 reset outputs", {pwm, flag, irq, oe}, 1);
    rst_n = 1'b1;

    // R2 R3 R5: table of mode / width / expected high count per period
    for (int v = 0; v < NV; v++) begin
      load_and_measure(V_MODE[v], V_VAL[v], h);
      check(h == V_EXP[v], "R2 R3 R5 table width", h, V_EXP[v]);
    end

    // R4 R5: forced-high period, then a mid-period write to 16
    load_and_measure(3'd7, 16'h8000, h);
    check(h == 128, "R5 forced high", h, 128);
    measure(128, 10, 16'h0010, h);
    check(h == 128, "R4 R5 force held until rollover", h, 128);
    measure(128, -1, 16'h0000, h);
    check(h == 16, "R5 force left at rollover", h, 16);

    // R4: mid-period width change 20 -> 100
    load_and_measure(3'd7, 16'h0014, h);
    check(h == 20, "R4 base width", h, 20);
    measure(128, 5, 16'h0064, h);
    check(h == 20, "R4 mid write ignored this period", h, 20);
    measure(128, -1, 16'h0000, h);
    check(h == 100, "R4 new width next period", h, 100);

    // R4: write on the rollover clock itself
    @(negedge clk);
    wr = 1'b1; wdata = 16'h0032; cnt = 16'h0000;
    @(posedge clk); #1 wr = 1'b0;
    measure(128, -1, 16'h0000, h);
    check(h == 100, "R4 write on rollover waits", h, 100);
    measure(128, -1, 16'h0000, h);
    check(h == 50, "R4 write on rollover applied later", h, 50);

    // R6: full resolution, 0xFFFF leaves one low count
    @(negedge clk);
    mode = 3'd0; wr = 1'b1; wdata = 16'hFFFF; cnt = 16'h0001;
    @(negedge clk);
    wr = 1'b0; cnt = 16'h0000;
    @(negedge clk);
    check(pwm == 1'b1, "R6 high after rollover", pwm, 1);
    cnt = 16'hFFFE;
    @(negedge clk);
    check(pwm == 1'b1, "R6 high before last count", pwm, 1);
    cnt = 16'hFFFF;
    @(negedge clk);
    check(pwm == 1'b0, "R6 low at 0xFFFF", pwm, 0);
    cnt = 16'h0000;
    @(negedge clk);
    check(pwm == 1'b1, "R6 high again after rollover", pwm, 1);
    // R6: bit 15 is a compare bit in mode 000
    wr = 1'b1; wdata = 16'h8000; cnt = 16'h0001;
    @(negedge clk);
    wr = 1'b0; cnt = 16'h0000;
    @(negedge clk);
    cnt = 16'h8000;
    @(negedge clk);
    cnt = 16'h8001;
    @(negedge clk);
    check(pwm == 1'b0, "R6 0x8000 compares, no force", pwm, 0);

    // R7: flag set, clear, and simultaneous set+clear
    mode = 3'd7; cnt = 16'h0005; fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    check(flag == 1'b0, "R7 flag cleared", flag, 0);
    cnt = 16'h0000;
    @(negedge clk);
    check(flag == 1'b1, "R7 flag set on rollover", flag, 1);
    // R8: level gating
    lvl = 3'd5; #1;
    check(irq == 1'b1 && irq_lvl == 3'd5, "R8 request at level 5", irq_lvl, 5);
    lvl = 3'd0; #1;
    check(irq == 1'b0 && irq_lvl == 3'd0, "R8 level zero disables", irq, 0);
    cnt = 16'h0000; fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    check(flag == 1'b1, "R7 set wins over clear", flag, 1);
    cnt = 16'h0003; fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    check(flag == 1'b0, "R7 clear strobe", flag, 0);

    // R9: drive mode
    load_and_measure(3'd7, 16'h8000, h);
    @(negedge clk); cnt = cnt + 16'd1;
    od = 1'b0; #1;
    check(pwm == 1'b1 && oe == 1'b1, "R9 push-pull drives high", oe, 1);
    od = 1'b1; #1;
    check(oe == 1'b0, "R9 open-drain releases high", oe, 0);
    load_and_measure(3'd7, 16'h0000, h);
    @(negedge clk); cnt = cnt + 16'd1;
    #1;
    check(pwm == 1'b0 && oe == 1'b1, "R9 open-drain drives low", oe, 1);
    od = 1'b0;

    // R10: freeze in the middle of a 40-count period
    load_and_measure(3'd7, 16'h0028, h);
    check(h == 40, "R10 base width", h, 40);
    h = 0; bad = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (pwm) h++;
      if (k == 10) begin
        held = pwm; saved = cnt;
        freeze = 1'b1; fclr = 1'b1; cnt = 16'h0000;
        for (int j = 0; j < 20; j++) begin
          @(negedge clk);
          fclr = 1'b0;
          if (pwm !== held) bad++;
          cnt = (j % 2 == 0) ? 16'h0028 : 16'h0000;
        end
        check(bad == 0, "R10 output held in freeze", bad, 0);
        check(flag == 1'b0, "R10 no flag set in freeze", flag, 0);
        freeze = 1'b0; cnt = saved;
      end
      cnt = cnt + 16'd1;
    end
    check(h == 40, "R10 period resumes intact", h, 40);

    finish_run();
  end

endmodule